// File: doc/BRIEF.md
# Cycle-Stealing DMA Bus Arbiter

This block is a small multi-channel DMA engine. It borrows the system bus from a processor, moving one word per bus cycle between a peripheral data register and memory in either direction. When any enabled channel has its request line high, the engine raises a hold request. It waits for the processor's hold acknowledge before it drives anything. Each move is a fly-by cycle: one bus cycle carries a source address and a destination address, and the memory system copies the word.

After every DMA cycle that completes, the engine leaves the next cycle idle for the processor. While work remains, the two therefore alternate and a long transfer cannot starve the processor. Each channel keeps its own addresses and count, so the next transfer is ready as soon as the idle cycle begins. The winner of that slot can be a different channel. Software programs each channel through a write-only configuration port. Each channel reports completion on a sticky done flag, which software clears by writing one to it.

The bus side is a valid/ready handshake. The engine presents `bus_valid` with a stable channel number and stable addresses until `bus_ready` is sampled high, and the cycle completes at that clock edge. There is one exception: when hold acknowledge falls, the engine withdraws the cycle and repeats it in full after the bus is granted again.

Top module: `dma_steal`

## Requirements
- R1: `hold_req` is high whenever some enabled channel has its request high or a bus cycle is outstanding, and it is low otherwise.
- R2: `bus_valid` rises only at an edge where `hold_ack` was high. If `hold_ack` is low at an edge, `bus_valid` is low after that edge and the cycle is dropped without counting. `bus_src`, `bus_dst` and `bus_ch` read zero whenever `bus_valid` is low.
- R3: A transfer for a channel starts only if that channel's request and enable are both high at the issuing edge. A request withdrawn before the grant produces no bus cycle.
- R4: After every completed cycle (`bus_valid` and `bus_ready` high with `hold_ack` high), `bus_valid` is low for the next cycle. With `bus_ready` held high and a request pending, valid cycles repeat every second cycle.
- R5: When several enabled channels request at once, the lowest-numbered channel is served first.
- R6: While `bus_valid` is high, `bus_ready` is low and `hold_ack` is high, the channel number and both addresses stay unchanged. Only a cycle sampled with `bus_ready` high counts.
- R7: Each completed cycle decrements the channel's count by one. The source address advances by one when its increment bit is set, and so does the destination address; an address whose bit is clear stays fixed. Addresses wrap modulo 2^AW.
- R8: The completion that takes a count to zero clears the enable bit and sets the done flag. A done flag stays set until a control write with bit 3 set. A finished channel ignores its request line.
- R9: The configuration write selects a field with `cfg_sel`: 0 is the source address, 1 the destination address, 2 the count and 3 control. In the control field, bit 0 is the enable, bit 1 the source increment, bit 2 the destination increment and bit 3 clears done. An enable written while the count is zero leaves the channel disabled.
- R10: After reset, all outputs are zero and every channel is disabled with its done flag clear.
- R11: When a second channel is pending as the first channel's last transfer completes, the second channel's cycle follows after exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req | output | 1 | Bus wanted by the engine |
| hold_ack | input | 1 | Bus granted by the processor |
| chan_req | input | NCH | Per-channel transfer request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | clog2(NCH) | Channel addressed by the write |
| cfg_sel | input | 2 | Field select, encoding in R9 |
| cfg_wdata | input | AW | Write data |
| done | output | NCH | Sticky per-channel completion flags |
| bus_valid | output | 1 | DMA bus cycle presented |
| bus_ready | input | 1 | Bus accepts the presented cycle |
| bus_ch | output | clog2(NCH) | Channel owning the presented cycle |
| bus_src | output | AW | Source word address |
| bus_dst | output | AW | Destination word address |

## Verification
The hardest situation to reach is a grant withdrawn in the middle of a DMA cycle. The engine must then let go of the bus within one cycle and later replay that same transfer without counting it twice. The bench gets there by holding `bus_ready` low to stall a presented cycle and removing `hold_acknowledge` while the stall lasts. It then restores both and checks the address sequence and the transfer total. A second hard case is a request that disappears before the grant. The bench reaches it by gating its grant model off, raising and dropping the request, and then re-enabling the grant.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  typedef enum logic [1:0] {
    FLD_SRC  = 2'd0,
    FLD_DST  = 2'd1,
    FLD_CNT  = 2'd2,
    FLD_CTRL = 2'd3
  } fld_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_SINC = 1;
  localparam int CTL_DINC = 2;
  localparam int CTL_DCLR = 3;
endpackage

// File: rtl/dma_steal_chan.sv
module dma_steal_chan
  import dma_steal_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          step,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          en_o,
  output logic          done_o
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          sinc, dinc;
  logic          last_step, clr_done;

  assign cnt_nxt   = step ? cnt - CW'(1) : cnt;
  assign last_step = step && (cnt == CW'(1));
  assign clr_done  = wr_en && (wr_sel == FLD_CTRL) && wr_data[CTL_DCLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt    <= '0;
      en_o   <= 1'b0;
      sinc   <= 1'b0;
      dinc   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      if (step) begin
        cnt <= cnt_nxt;
        if (sinc) src_o <= src_o + AW'(1);
        if (dinc) dst_o <= dst_o + AW'(1);
        if (last_step) en_o <= 1'b0;
      end
      if (wr_en) begin
        case (fld_e'(wr_sel))
          FLD_SRC: src_o <= wr_data;
          FLD_DST: dst_o <= wr_data;
          FLD_CNT: cnt   <= wr_data[CW-1:0];
          default: begin
            en_o <= wr_data[CTL_EN] && (cnt_nxt != '0);
            sinc <= wr_data[CTL_SINC];
            dinc <= wr_data[CTL_DINC];
          end
        endcase
      end
      done_o <= last_step || (done_o && !clr_done);
    end
  end
endmodule

// File: rtl/dma_steal_pick.sv
module dma_steal_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_steal.sv
module dma_steal #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int CW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           hold_req,
  input  logic           hold_ack,
  input  logic [NCH-1:0] chan_req,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [NCH-1:0] done,
  output logic           bus_valid,
  input  logic           bus_ready,
  output logic [IW-1:0]  bus_ch,
  output logic [AW-1:0]  bus_src,
  output logic [AW-1:0]  bus_dst
);
  logic [AW-1:0]  src_arr [NCH];
  logic [AW-1:0]  dst_arr [NCH];
  logic [NCH-1:0] en_vec;
  logic [NCH-1:0] pend;
  logic           any_pend;
  logic [IW-1:0]  win;
  logic           complete, issue;

  assign complete = bus_valid && bus_ready && hold_ack;
  assign issue    = hold_ack && !bus_valid && any_pend;
  assign pend     = chan_req & en_vec;
  assign hold_req = any_pend || bus_valid;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_steal_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && (cfg_ch == IW'(g))),
      .wr_sel (cfg_sel),
      .wr_data(cfg_wdata),
      .step   (complete && (bus_ch == IW'(g))),
      .src_o  (src_arr[g]),
      .dst_o  (dst_arr[g]),
      .en_o   (en_vec[g]),
      .done_o (done[g])
    );
  end

  dma_steal_pick #(.N(NCH), .IW(IW)) u_pick (
    .req(pend),
    .any(any_pend),
    .idx(win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_ch    <= '0;
      bus_src   <= '0;
      bus_dst   <= '0;
    end else if (!hold_ack || complete) begin
      bus_valid <= 1'b0;
      bus_ch    <= '0;
      bus_src   <= '0;
      bus_dst   <= '0;
    end else if (issue) begin
      bus_valid <= 1'b1;
      bus_ch    <= win;
      bus_src   <= src_arr[win];
      bus_dst   <= dst_arr[win];
    end
  end
endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int IW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic [NCH-1:0] chan_req,
  input logic           clr_any,
  input logic [NCH-1:0] done,
  input logic           bus_valid,
  input logic           bus_ready,
  input logic [IW-1:0]  bus_ch,
  input logic [AW-1:0]  bus_src,
  input logic [AW-1:0]  bus_dst
);
  logic [NCH-1:0] req_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= chan_req;
  end

  p_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack |=> !bus_valid);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_src == '0 && bus_dst == '0 && bus_ch == '0));

  p_req_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> req_q[bus_ch]);

  p_cpu_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && hold_ack) |=> !bus_valid);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && hold_ack) |=>
      (bus_valid && $stable(bus_src) && $stable(bus_dst) && $stable(bus_ch)));

  p_busy_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> hold_req);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req == '0 && !bus_valid) |-> !hold_req);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_any |=> (($past(done) & ~done) == '0));
endmodule

bind dma_steal dma_steal_chk #(.NCH(NCH), .AW(AW), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .chan_req (chan_req),
  .clr_any  (cfg_we && (cfg_sel == 2'd3) && cfg_wdata[3]),
  .done     (done),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_ch   (bus_ch),
  .bus_src  (bus_src),
  .bus_dst  (bus_dst)
);

// File: tb/dma_steal_bench.sv
`timescale 1ns/1ps
module dma_steal_bench;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam int CW  = 8;
  localparam int IW  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           hold_req, hold_ack;
  logic [NCH-1:0] chan_req;
  logic           cfg_we;
  logic [IW-1:0]  cfg_ch;
  logic [1:0]     cfg_sel;
  logic [AW-1:0]  cfg_wdata;
  logic [NCH-1:0] done;
  logic           bus_valid, bus_ready;
  logic [IW-1:0]  bus_ch;
  logic [AW-1:0]  bus_src, bus_dst;

  int  checks = 0;
  int  fails  = 0;
  bit  ack_en = 1'b1;

  dma_steal #(.NCH(NCH), .AW(AW), .CW(CW)) u_dma_steal (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
    .chan_req(chan_req), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done(done), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_ch(bus_ch), .bus_src(bus_src), .bus_dst(bus_dst)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; grant model follows hold_req with one cycle of lag
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    hold_ack = ack_en && hold_req;
  endtask

  task automatic wr(int ch, int sel, int data);
    cfg_we = 1'b1; cfg_ch = IW'(ch); cfg_sel = 2'(sel); cfg_wdata = AW'(data);
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic program_ch(int ch, int s, int d, int n, bit si, bit di);
    wr(ch, 0, s);
    wr(ch, 1, d);
    wr(ch, 2, n);
    wr(ch, 3, {di, si, 1'b1});
  endtask

  // R7 R4 R8 R9: single channel run with ready held high
  task automatic run_xfer(int ch, int n, bit si, bit di, logic [AW-1:0] s0, logic [AW-1:0] d0);
    int k = 0, first = -1, last = -1, bad_addr = 0, bad_gap = 0;
    bit prev_cmp = 0;
    logic [AW-1:0] es, ed;
    program_ch(ch, s0, d0, n, si, di);
    chan_req[ch] = 1'b1;
    for (int t = 0; t < 4 * n + 10; t++) begin
      cyc();
      if (prev_cmp && bus_valid) bad_gap++;
      prev_cmp = bus_valid && bus_ready;
      if (bus_valid) begin
        es = s0 + (si ? AW'(k) : AW'(0));
        ed = d0 + (di ? AW'(k) : AW'(0));
        if (bus_src != es || bus_dst != ed || bus_ch != IW'(ch)) bad_addr++;
        if (first < 0) first = t;
        last = t;
        k++;
      end
    end
    chk(k == n, "R7 transfer total", k, n);
    chk(bad_addr == 0, "R7 address sequence", bad_addr, 0);
    chk(bad_gap == 0, "R4 idle cycle after completion", bad_gap, 0);
    chk(last - first == 2 * (n - 1), "R4 alternation span", last - first, 2 * (n - 1));
    chk(done[ch] == 1'b1, "R8 done set", done[ch], 1);
    chk(hold_req == 1'b0, "R8 finished channel ignores request", hold_req, 0);
    chan_req[ch] = 1'b0;
    cyc();
    chk(done[ch] == 1'b1, "R8 done sticky", done[ch], 1);
    wr(ch, 3, 8);
    chk(done[ch] == 1'b0, "R8 done cleared by write", done[ch], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k, cnt, stalls, bad, first_s;
    int seq [8];
    int tim [8];
    bit prev_cmp;
    rst_n = 1'b0; hold_ack = 1'b0; chan_req = '0; cfg_we = 1'b0;
    cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0; bus_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R10 reset state
    chk(hold_req == 1'b0, "R10 hold_req", hold_req, 0);
    chk(bus_valid == 1'b0, "R10 bus_valid", bus_valid, 0);
    chk(done == '0, "R10 done", done, 0);
    chk(bus_src == '0 && bus_dst == '0, "R10 addresses", bus_src, 0);

    // sweep: every channel, counts 1..4, every increment combination
    for (int ch = 0; ch < NCH; ch++)
      for (int n = 1; n <= 4; n++)
        for (int m = 0; m < 4; m++)
          run_xfer(ch, n, m[0], m[1], AW'(8'hFD - ch), AW'(8'h40 + 16 * ch));

    // R5 R11: two channels at once
    program_ch(2, 8'h20, 8'h30, 2, 1, 1);
    program_ch(1, 8'h10, 8'h40, 2, 1, 1);
    chan_req = 4'b0110;
    k = 0;
    for (int t = 0; t < 20; t++) begin
      cyc();
      if (bus_valid && k < 8) begin seq[k] = int'(bus_ch); tim[k] = t; k++; end
    end
    chk(k == 4, "R5 total cycles", k, 4);
    chk(seq[0] == 1 && seq[1] == 1, "R5 lower channel first", seq[1], 1);
    chk(seq[2] == 2 && seq[3] == 2, "R5 higher channel after", seq[2], 2);
    chk(tim[2] - tim[1] == 2, "R11 next channel after one idle cycle", tim[2] - tim[1], 2);
    chk(tim[3] - tim[0] == 6, "R4 alternation over both channels", tim[3] - tim[0], 6);
    chan_req = '0;
    wr(1, 3, 8); wr(2, 3, 8);

    // R6: back-pressure with a ready pattern
    program_ch(0, 8'h80, 8'h90, 3, 1, 0);
    chan_req[0] = 1'b1;
    k = 0; stalls = 0; bad = 0; prev_cmp = 0;
    for (int t = 0; t < 40; t++) begin
      cyc();
      bus_ready = ((t % 3) == 2);
      if (prev_cmp && bus_valid) bad++;
      prev_cmp = 0;
      if (bus_valid) begin
        if (bus_src != AW'(8'h80 + k) || bus_dst != AW'(8'h90)) bad++;
        if (bus_ready) begin k++; prev_cmp = 1; end
        else stalls++;
      end
    end
    bus_ready = 1'b1;
    chk(bad == 0, "R6 stable addresses while stalled", bad, 0);
    chk(stalls > 0, "R6 stalls exercised", stalls, 1);
    chk(k == 3, "R6 only ready cycles count", k, 3);
    chk(done[0] == 1'b1, "R8 done after stalled run", done[0], 1);
    chan_req = '0;
    wr(0, 3, 8);

    // R2: grant withdrawn while a cycle is stalled
    program_ch(0, 8'h50, 8'h60, 2, 1, 1);
    bus_ready = 1'b0;
    chan_req[0] = 1'b1;
    for (int t = 0; t < 6 && !bus_valid; t++) cyc();
    chk(bus_valid == 1'b1, "R2 cycle presented under grant", bus_valid, 1);
    ack_en = 1'b0;
    hold_ack = 1'b0;
    cyc();
    chk(bus_valid == 1'b0, "R2 release after grant loss", bus_valid, 0);
    chk(bus_src == '0, "R2 outputs zero when released", bus_src, 0);
    cnt = 0;
    for (int t = 0; t < 4; t++) begin
      cyc();
      if (bus_valid) cnt++;
    end
    chk(cnt == 0, "R2 no cycle without grant", cnt, 0);
    chk(hold_req == 1'b1, "R1 request kept while pending", hold_req, 1);
    ack_en = 1'b1; bus_ready = 1'b1;
    k = 0; first_s = -1;
    for (int t = 0; t < 20; t++) begin
      cyc();
      if (bus_valid) begin
        if (first_s < 0) first_s = int'(bus_src);
        k++;
      end
    end
    chk(first_s == 8'h50, "R2 aborted transfer replayed", first_s, 8'h50);
    chk(k == 2, "R2 aborted cycle not counted", k, 2);
    chan_req = '0;
    wr(0, 3, 8);

    // R3: request withdrawn before the grant
    ack_en = 1'b0; hold_ack = 1'b0;
    program_ch(3, 8'h11, 8'h22, 1, 0, 0);
    chan_req[3] = 1'b1;
    cyc();
    chk(hold_req == 1'b1, "R1 request raised", hold_req, 1);
    chan_req[3] = 1'b0;
    ack_en = 1'b1;
    cnt = 0;
    for (int t = 0; t < 6; t++) begin
      cyc();
      if (bus_valid) cnt++;
    end
    chk(cnt == 0, "R3 withdrawn request gives no cycle", cnt, 0);
    chk(hold_req == 1'b0, "R1 request dropped", hold_req, 0);
    chk(done[3] == 1'b0, "R3 no completion", done[3], 0);

    // R9: enable with a zero count is refused
    wr(2, 2, 0);
    wr(2, 3, 1);
    chan_req[2] = 1'b1;
    cnt = 0;
    for (int t = 0; t < 4; t++) begin
      cyc();
      if (bus_valid || hold_req) cnt++;
    end
    chk(cnt == 0, "R9 zero count keeps channel disabled", cnt, 0);
    chan_req = '0;
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule